// File: doc/BRIEF.md
# Parallel-Port Adapter Attach/Release Sequencer

This block brings a parallel-port disk-bridge adapter into a usable session and later hands the port back. When attachment is asked for, it first records the values the host port currently shows on its data and control lines. It then steps the port outputs through a fixed wake-up pattern. In the enhanced (EPP-class) modes it adds a further enable pattern. It finishes by asking an external register engine to write one adapter register. When release is asked for, it steps through a short release pattern and puts the recorded data and control values back.

Every step holds its value for a programmable number of cycles. The mode and the step delay are captured when a request is accepted, so that one sequence always runs with a single setting. A `connected` flag tells the surrounding logic whether a session is open.

The controller has four named states. IDLE waits for a request. ATTACH plays the attach steps. REGWR holds the register-write request until the engine answers. RELEASE plays the release steps. The transitions are:
- accept-attach: IDLE to ATTACH.
- accept-release: IDLE to RELEASE.
- attach-done: ATTACH to REGWR, after the last attach step.
- write-ack: REGWR to IDLE, when `regw_done` is seen.
- release-done: RELEASE to IDLE, after the last release step.

Top module: `pport_attach_seq`

## Requirements
- R1: After reset `data_out` is 0x00, `ctrl_out` is 0x04, and `regw_req`, `connected` and `busy` are all 0.
- R2: In IDLE with `connected`=0, a sampled `conn_req`=1 captures `port_data_in` and `port_ctrl_in` and starts nine attach steps. Each step sets one output, in this order: ctrl 0x04; data 0xA0, 0x50, 0xC0, 0x30, 0xA0, 0x00; ctrl 0x01; ctrl 0x04.
- R3: If `mode` (3 bits) is 3 or more at acceptance, ten more steps follow the nine: data 0x0A; ctrl 0x01, 0x04; data 0x82; ctrl 0x04, 0x0C, 0x04, 0x24, 0x26, 0x04.
- R4: Let the accepting clock edge be E, and let D be `step_dly` sampled at E. Step k takes effect at edge E+k·(D+1), and each step's value is held for D+1 cycles.
- R5: One step period after the last attach step, `regw_req` rises with `regw_addr`=0x86 and `regw_data`=0x08. All three stay stable until `regw_done` is sampled high while the request is up.
- R6: At the edge where `regw_done` is accepted, `regw_req` drops, `connected` sets and `busy` clears. `regw_done` has no effect when no request is up.
- R7: In IDLE with `connected`=1, a sampled `disc_req`=1 starts five release steps with the same timing as R4. In order they are: data = captured data; ctrl 0x01; ctrl 0x04; data = captured data; ctrl = captured ctrl. One step period after the last step, `connected` and `busy` clear.
- R8: `conn_req` while connected, `disc_req` while not connected, and any request while `busy`=1 are all ignored.
- R9: When `conn_req` and `disc_req` are both high in the same IDLE cycle, the request that fits the `connected` state wins: release if connected, attach otherwise.
- R10: Changes to `mode` or `step_dly` after acceptance do not alter the running sequence.
- R11: `busy` is 1 from the accepting edge until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Transfer mode; 3 and above selects the enhanced enable pattern |
| step_dly | input | DLY_W | Extra hold cycles per step |
| conn_req | input | 1 | Attach request |
| disc_req | input | 1 | Release request |
| port_data_in | input | 8 | Current host data-port value |
| port_ctrl_in | input | 8 | Current host control-port value |
| data_out | output | 8 | Driven data-port value |
| ctrl_out | output | 8 | Driven control-port value |
| regw_req | output | 1 | Register-write request to the engine |
| regw_addr | output | 8 | Adapter register address |
| regw_data | output | 8 | Value to write |
| regw_done | input | 1 | Engine completion |
| busy | output | 1 | Sequence in progress |
| connected | output | 1 | Session open |

## Verification
An attach request and a release request can reach the controller in the same IDLE cycle. The bench raises both together once while disconnected and once while connected. It then checks that only the matching sequence starts, by comparing every step's data and control values against its own model.

Requests that arrive during a running sequence, and mode or delay changes made mid-sequence, are also issued. The bench confirms that the step trace and the step timing still match the values captured at acceptance.

// File: rtl/pas_pkg.sv
package pas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ATTACH  = 2'd1,
        ST_REGWR   = 2'd2,
        ST_RELEASE = 2'd3
    } pas_state_e;

    localparam int IDX_W        = 5;
    localparam int BASE_STEPS   = 9;
    localparam int ENH_STEPS    = 19;
    localparam int REL_STEPS    = 5;
    localparam int ENH_MODE_MIN = 3;

    localparam logic [7:0] WAKE_REG_ADDR = 8'h86;
    localparam logic [7:0] WAKE_REG_VAL  = 8'h08;
    localparam logic [7:0] RST_DATA      = 8'h00;
    localparam logic [7:0] RST_CTRL      = 8'h04;

    typedef struct packed {
        logic       to_ctrl;
        logic [7:0] val;
    } pas_step_t;

endpackage

// File: rtl/pas_step_rom.sv
module pas_step_rom
    import pas_pkg::*;
(
    input  logic             release_seq,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       sav_data,
    input  logic [7:0]       sav_ctrl,
    output pas_step_t        step
);

    function automatic pas_step_t mk(input logic c, input logic [7:0] v);
        pas_step_t s;
        s.to_ctrl = c;
        s.val     = v;
        return s;
    endfunction

    always_comb begin
        step = mk(1'b1, RST_CTRL);
        if (release_seq) begin
            unique case (idx)
                5'd0:    step = mk(1'b0, sav_data);
                5'd1:    step = mk(1'b1, 8'h01);
                5'd2:    step = mk(1'b1, 8'h04);
                5'd3:    step = mk(1'b0, sav_data);
                default: step = mk(1'b1, sav_ctrl);
            endcase
        end else begin
            unique case (idx)
                5'd0:    step = mk(1'b1, 8'h04);
                5'd1:    step = mk(1'b0, 8'hA0);
                5'd2:    step = mk(1'b0, 8'h50);
                5'd3:    step = mk(1'b0, 8'hC0);
                5'd4:    step = mk(1'b0, 8'h30);
                5'd5:    step = mk(1'b0, 8'hA0);
                5'd6:    step = mk(1'b0, 8'h00);
                5'd7:    step = mk(1'b1, 8'h01);
                5'd8:    step = mk(1'b1, 8'h04);
                5'd9:    step = mk(1'b0, 8'h0A);
                5'd10:   step = mk(1'b1, 8'h01);
                5'd11:   step = mk(1'b1, 8'h04);
                5'd12:   step = mk(1'b0, 8'h82);
                5'd13:   step = mk(1'b1, 8'h04);
                5'd14:   step = mk(1'b1, 8'h0C);
                5'd15:   step = mk(1'b1, 8'h04);
                5'd16:   step = mk(1'b1, 8'h24);
                5'd17:   step = mk(1'b1, 8'h26);
                default: step = mk(1'b1, 8'h04);
            endcase
        end
    end

endmodule

// File: rtl/pas_hold_timer.sv
module pas_hold_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DLY_W-1:0] limit,
    output logic             hold_done,
    output logic             fresh
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (restart)    cnt_q <= '0;
        else if (!hold_done) cnt_q <= cnt_q + 1'b1;
    end

    assign hold_done = (cnt_q == limit);
    assign fresh     = (cnt_q == '0);

    // R4: the counter never passes the limit
    p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_done && !restart) |=> hold_done);

endmodule

// File: rtl/pport_attach_seq.sv
module pport_attach_seq
    import pas_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic [DLY_W-1:0] step_dly,
    input  logic             conn_req,
    input  logic             disc_req,
    input  logic [7:0]       port_data_in,
    input  logic [7:0]       port_ctrl_in,
    output logic [7:0]       data_out,
    output logic [7:0]       ctrl_out,
    output logic             regw_req,
    output logic [7:0]       regw_addr,
    output logic [7:0]       regw_data,
    input  logic             regw_done,
    output logic             busy,
    output logic             connected
);

    pas_state_e       st_q;
    logic [IDX_W-1:0] idx_q, rom_idx;
    logic [7:0]       sav_d_q, sav_c_q, data_q, ctrl_q;
    logic [DLY_W-1:0] dly_q;
    logic             enh_q, req_q, conn_q;
    logic             acc_att, acc_rel, stepping, advance, last, restart;
    logic             hold_done, fresh;
    logic [IDX_W-1:0] last_idx;
    pas_step_t        step;

    assign acc_att  = (st_q == ST_IDLE) && conn_req && !conn_q;
    assign acc_rel  = (st_q == ST_IDLE) && disc_req && conn_q;
    assign stepping = (st_q == ST_ATTACH) || (st_q == ST_RELEASE);
    assign advance  = stepping && hold_done;
    assign last_idx = (st_q == ST_RELEASE) ? IDX_W'(REL_STEPS - 1)
                    : (enh_q ? IDX_W'(ENH_STEPS - 1) : IDX_W'(BASE_STEPS - 1));
    assign last     = (idx_q == last_idx);
    assign restart  = acc_att || acc_rel || (advance && !last);
    assign rom_idx  = (acc_att || acc_rel) ? '0 : idx_q + 1'b1;

    pas_step_rom u_rom (
        .release_seq (acc_rel || (st_q == ST_RELEASE)),
        .idx         (rom_idx),
        .sav_data    (sav_d_q),
        .sav_ctrl    (sav_c_q),
        .step        (step)
    );

    pas_hold_timer #(.DLY_W(DLY_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .limit     (dly_q),
        .hold_done (hold_done),
        .fresh     (fresh)
    );

    // State register and step index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (acc_rel)      st_q <= ST_RELEASE;
                    else if (acc_att) st_q <= ST_ATTACH;
                end
                ST_ATTACH: if (advance) begin
                    if (last) st_q  <= ST_REGWR;
                    else      idx_q <= idx_q + 1'b1;
                end
                ST_REGWR: if (regw_done) st_q <= ST_IDLE;
                ST_RELEASE: if (advance) begin
                    if (last) st_q  <= ST_IDLE;
                    else      idx_q <= idx_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port values, captured settings, handshake and session flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= RST_DATA;
            ctrl_q  <= RST_CTRL;
            sav_d_q <= '0;
            sav_c_q <= '0;
            dly_q   <= '0;
            enh_q   <= 1'b0;
            req_q   <= 1'b0;
            conn_q  <= 1'b0;
        end else begin
            if (acc_att) begin
                sav_d_q <= port_data_in;
                sav_c_q <= port_ctrl_in;
                enh_q   <= (mode >= 3'(ENH_MODE_MIN));
            end
            if (acc_att || acc_rel) dly_q <= step_dly;
            if (acc_att || acc_rel || (advance && !last)) begin
                if (step.to_ctrl) ctrl_q <= step.val;
                else              data_q <= step.val;
            end
            if ((st_q == ST_ATTACH) && advance && last) req_q <= 1'b1;
            if ((st_q == ST_REGWR) && regw_done) begin
                req_q  <= 1'b0;
                conn_q <= 1'b1;
            end
            if ((st_q == ST_RELEASE) && advance && last) conn_q <= 1'b0;
        end
    end

    assign data_out  = data_q;
    assign ctrl_out  = ctrl_q;
    assign regw_req  = req_q;
    assign regw_addr = WAKE_REG_ADDR;
    assign regw_data = WAKE_REG_VAL;
    assign busy      = (st_q != ST_IDLE);
    assign connected = conn_q;

    // R5: the request stays up until the engine answers
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (regw_req && !regw_done) |=> regw_req);
    // R6: the session flag rises only on an accepted write
    p_conn_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connected) |-> $past(regw_req && regw_done));
    // R11: no request is up outside a sequence
    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !regw_req);
    // R4: port values hold between step edges
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !fresh) |-> ($stable(data_out) && $stable(ctrl_out)));
    // R7: the session flag falls only at the end of a release
    p_rel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(connected) |-> (!busy && $past(st_q == ST_RELEASE)));

endmodule

// File: tb/pport_attach_seq_bench.sv
`timescale 1ns/1ps
module pport_attach_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] step_dly = '0;
    logic       conn_req = 1'b0, disc_req = 1'b0, regw_done = 1'b0;
    logic [7:0] port_data_in = '0, port_ctrl_in = '0;
    logic [7:0] data_out, ctrl_out, regw_addr, regw_data;
    logic       regw_req, busy, connected;

    int  nchk = 0, nerr = 0;
    bit  ended = 0;
    logic [7:0] exp_d = 8'h00, exp_c = 8'h04, sav_d = 8'h00, sav_c = 8'h00;

    always #2 clk = ~clk;

    pport_attach_seq u_pport_attach_seq (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // {to_ctrl, value} for attach step k
    function automatic logic [8:0] att_step(input int k);
        logic [8:0] t [19] = '{9'h104, 9'h0A0, 9'h050, 9'h0C0, 9'h030, 9'h0A0, 9'h000,
                               9'h101, 9'h104, 9'h00A, 9'h101, 9'h104, 9'h082, 9'h104,
                               9'h10C, 9'h104, 9'h124, 9'h126, 9'h104};
        return t[k];
    endfunction

    function automatic logic [8:0] rel_step(input int k, input logic [7:0] d, input logic [7:0] c);
        case (k)
            0, 3:    return {1'b0, d};
            1:       return 9'h101;
            2:       return 9'h104;
            default: return {1'b1, c};
        endcase
    endfunction

    task automatic apply_exp(input logic [8:0] s);
        if (s[8]) exp_c = s[7:0];
        else      exp_d = s[7:0];
    endtask

    task automatic idle_check(input string tag, input logic expc);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " connected"}, connected, expc);
        chk({tag, " data"}, data_out, exp_d);
        chk({tag, " ctrl"}, ctrl_out, exp_c);
        chk({tag, " req"}, regw_req, 0);
    endtask

    // Drives one request and follows the whole sequence; both: raise both lines
    task automatic session(input logic rel, input logic both, input logic [2:0] m,
                           input logic [7:0] d, input int wait_ack);
        int n;
        @(negedge clk);
        mode = m; step_dly = d;
        port_data_in = 8'($urandom); port_ctrl_in = 8'($urandom);
        conn_req = !rel || both; disc_req = rel || both;
        @(posedge clk);
        if (!rel) begin sav_d = port_data_in; sav_c = port_ctrl_in; end
        @(negedge clk);
        conn_req = 0; disc_req = 0;
        // R10: disturb mode and delay after acceptance
        mode = 3'($urandom); step_dly = 8'($urandom_range(0, 5));
        n = rel ? 5 : ((m >= 3) ? 19 : 9);
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                repeat (d + 1) @(posedge clk);
                @(negedge clk);
            end
            if (k == 1) begin conn_req = 1; disc_req = 1; end   // R8: ignored while busy
            if (k == 2) begin conn_req = 0; disc_req = 0; end
            apply_exp(rel ? rel_step(k, sav_d, sav_c) : att_step(k));
            chk(rel ? "R7 release step data" : (k < 9 ? "R2 attach data" : "R3 enh data"),
                data_out, exp_d);
            chk(rel ? "R7 release step ctrl" : (k < 9 ? "R2 attach ctrl" : "R3 enh ctrl"),
                ctrl_out, exp_c);
            chk("R11 busy in sequence", busy, 1);
        end
        conn_req = 0; disc_req = 0;
        repeat (d + 1) @(posedge clk);
        @(negedge clk);
        if (rel) begin
            idle_check("R7 after release", 0);
        end else begin
            chk("R5 req raised", regw_req, 1);
            chk("R5 addr", regw_addr, 8'h86);
            chk("R5 data", regw_data, 8'h08);
            repeat (wait_ack) begin
                @(negedge clk);
                chk("R5 req held", regw_req, 1);
            end
            regw_done = 1;
            @(negedge clk);
            regw_done = 0;
            idle_check("R6 after ack", 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset data", data_out, 8'h00);
        chk("R1 reset ctrl", ctrl_out, 8'h04);
        chk("R1 reset req", regw_req, 0);
        chk("R1 reset connected", connected, 0);
        chk("R1 reset busy", busy, 0);

        // R8: release while disconnected ignored; R6: stray done ignored
        disc_req = 1; regw_done = 1;
        @(negedge clk);
        disc_req = 0; regw_done = 0;
        repeat (3) @(negedge clk);
        idle_check("R8 release ignored", 0);

        // Directed: zero delay, base and enhanced modes
        session(0, 0, 3'd0, 8'd0, 0);
        // R8: attach while connected ignored
        conn_req = 1;
        @(negedge clk);
        conn_req = 0;
        repeat (2) @(negedge clk);
        idle_check("R8 attach ignored", 1);
        session(1, 1, 3'd5, 8'd2, 0);          // R9: both, connected -> release
        session(0, 1, 3'd3, 8'd0, 3);          // R9: both, disconnected -> attach
        session(1, 0, 3'd0, 8'd0, 0);
        session(0, 0, 3'd7, 8'd3, 1);
        session(1, 0, 3'd2, 8'd1, 0);

        for (int i = 0; i < 20; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            session(0, 1'($urandom), m, 8'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
            session(1, 1'($urandom), 3'($urandom), 8'($urandom_range(0, 4)), 0);
        end

        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule